// File: doc/BRIEF.md
# Cascaded LED Driver Frame Transmitter

This block is the host side of a serial link to a chain of identical LED driver devices wired in cascade, each one passing its input stream on to the next. The block presents one serial clock output and one serial data output. For every device it reads a settings slice from wide input vectors: five function bits, three 7-bit brightness values (blue, green, red) and twelve 16-bit grayscale values. From each slice it builds a 224-bit packet that opens with a fixed write command. On a start request it shifts all packets out back to back with the most significant bit first. The device that sits farthest down the chain is served first. A frame has no strobe line. It is closed only by holding the serial clock low for nine bit periods, which gives every device time to latch.

The controller is a four-state machine. IDLE waits for `start`. The IDLE→SEND transition loads the packet for the farthest device. SEND toggles the serial clock at a rate set by a divider. Each time SEND completes a packet it loads the next nearer device's packet, and after the packet for device 0 it takes the SEND→HOLD transition. HOLD counts the latch gap in system clocks. The HOLD→FIN transition fires when that count expires. FIN lasts one cycle, raises `done`, and takes the FIN→IDLE transition. Any change to any device's settings means the whole chain has to be rewritten, so the host issues a fresh start. The settings inputs are read at the moment each packet is loaded, and they must stay stable while `busy` is high.

Top module: `dcp_tx`

## Requirements
- R1: Every packet is 224 bits long and its first six bits on the wire are 1,0,0,1,0,1 (command value 0x25).
- R2: After the command, a packet carries the five function bits, then blue, green and red brightness (7 bits each), then twelve 16-bit grayscale values. The grayscale channel with index 11 is sent first and index 0 last, where channel index = 3·n + colour (red 0, green 1, blue 2) and the slice for device d, channel c is `dev_gray[d*192 + c*16 +: 16]`. Every field is sent MSB first.
- R3: A frame has exactly 224 × N_DEV rising edges of `sclk`.
- R4: The packet built from device slice N_DEV−1 is sent first and the one from slice 0 is sent last.
- R5: Within a frame, `sclk` is high for exactly CLK_DIV system clocks and low for exactly CLK_DIV system clocks for every bit, and there is no gap between packets.
- R6: `sdo` changes only while `sclk` is low. It never changes while `sclk` stays high.
- R7: After the last falling edge of a frame, `sclk` stays low for exactly 18·CLK_DIV system clocks (nine bit periods) before `done` rises.
- R8: `done` is high for exactly one cycle, and `busy` falls in the next cycle. `busy` is high from the cycle after an accepted start up to and including the `done` cycle.
- R9: A `start` that is high while `busy` is high is ignored. This includes the `done` cycle. Such a start produces no extra clock pulses and no second frame.
- R10: During and after reset, while no frame runs, `sclk`, `sdo`, `busy` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, accepted only in IDLE |
| dev_func | input | N_DEV*5 | Function bits, 5 per device |
| dev_blue | input | N_DEV*7 | Blue brightness, 7 per device |
| dev_green | input | N_DEV*7 | Green brightness, 7 per device |
| dev_red | input | N_DEV*7 | Red brightness, 7 per device |
| dev_gray | input | N_DEV*192 | Grayscale, 12 × 16 bits per device |
| sclk | output | 1 | Serial clock to the chain, idles low |
| sdo | output | 1 | Serial data, changes after falling edges |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
Two collisions matter. In the first, a packet boundary falls on the same falling-clock edge that loads the next device's packet. The bench sweeps several data patterns, including all-zero and all-one settings, over a three-device chain and rebuilds every field of every packet from the captured bits. It also checks each clock width, so a lost or doubled bit or a stretched half-period at a boundary shows up as a count or width mismatch. In the second, a new start request arrives in the exact cycle that `done` pulses, and also in the middle of a frame. The bench raises `start` in both places and judges the result by the pulse count, by a single `done`, and by `busy` and `sclk` staying low afterwards.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
    localparam int PKT_BITS  = 224;
    localparam int CMD_BITS  = 6;
    localparam int FUNC_BITS = 5;
    localparam int BRT_BITS  = 7;
    localparam int GS_BITS   = 16;
    localparam int GS_CH     = 12;
    localparam int GS_SLICE  = GS_BITS * GS_CH;
    localparam int HOLD_BITS = 9;
    localparam logic [CMD_BITS-1:0] CMD_WRITE = 6'h25;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_HOLD,
        ST_FIN
    } tx_state_t;
endpackage

// File: rtl/dcp_baud.sv
module dcp_baud #(
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(CLK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/dcp_packer.sv
module dcp_packer
    import dcp_pkg::*;
#(
    parameter int N_DEV  = 2,
    parameter int DSEL_W = 1
) (
    input  logic [DSEL_W-1:0]          dev_sel,
    input  logic [N_DEV*FUNC_BITS-1:0] func,
    input  logic [N_DEV*BRT_BITS-1:0]  blue,
    input  logic [N_DEV*BRT_BITS-1:0]  green,
    input  logic [N_DEV*BRT_BITS-1:0]  red,
    input  logic [N_DEV*GS_SLICE-1:0]  gray,
    output logic [PKT_BITS-1:0]        pkt
);
    int idx;

    always_comb begin
        idx = int'(dev_sel);
        if (idx >= N_DEV) begin
            idx = 0;
        end
        pkt = {CMD_WRITE,
               func[idx*FUNC_BITS +: FUNC_BITS],
               blue[idx*BRT_BITS +: BRT_BITS],
               green[idx*BRT_BITS +: BRT_BITS],
               red[idx*BRT_BITS +: BRT_BITS],
               gray[idx*GS_SLICE +: GS_SLICE]};
    end
endmodule

// File: rtl/dcp_shifter.sv
module dcp_shifter #(
    parameter int W = 224
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         msb,
    output logic         last
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sreg_q;
    logic [CW-1:0] pos_q;

    assign msb  = sreg_q[W-1];
    assign last = (pos_q == CW'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            pos_q  <= '0;
        end else if (load) begin
            sreg_q <= din;
            pos_q  <= '0;
        end else if (shift) begin
            sreg_q <= {sreg_q[W-2:0], 1'b0};
            pos_q  <= pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/dcp_tx.sv
module dcp_tx
    import dcp_pkg::*;
#(
    parameter int N_DEV   = 2,
    parameter int CLK_DIV = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [N_DEV*FUNC_BITS-1:0] dev_func,
    input  logic [N_DEV*BRT_BITS-1:0]  dev_blue,
    input  logic [N_DEV*BRT_BITS-1:0]  dev_green,
    input  logic [N_DEV*BRT_BITS-1:0]  dev_red,
    input  logic [N_DEV*GS_SLICE-1:0]  dev_gray,
    output logic                       sclk,
    output logic                       sdo,
    output logic                       busy,
    output logic                       done
);
    localparam int DW       = (N_DEV > 1) ? $clog2(N_DEV) : 1;
    localparam int HOLD_CYC = 2 * CLK_DIV * HOLD_BITS;
    localparam int HW       = $clog2(HOLD_CYC + 1);

    tx_state_t state_q, state_d;
    logic          sclk_q;
    logic [DW-1:0] dev_q;
    logic [HW-1:0] hold_q;
    logic          tick, fall_evt, pkt_end, accept, load, shift_en;
    logic          bit_msb, bit_last;
    logic [DW-1:0] dev_pick;
    logic [PKT_BITS-1:0] pkt;

    dcp_baud #(.CLK_DIV(CLK_DIV)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q == ST_SEND),
        .tick (tick)
    );

    assign accept   = (state_q == ST_IDLE) && start;
    assign fall_evt = tick && sclk_q;
    assign pkt_end  = fall_evt && bit_last;
    assign load     = accept || (pkt_end && (dev_q != '0));
    assign shift_en = fall_evt && !bit_last;
    assign dev_pick = accept ? DW'(N_DEV - 1) : (dev_q - 1'b1);

    dcp_packer #(.N_DEV(N_DEV), .DSEL_W(DW)) u_packer (
        .dev_sel(dev_pick),
        .func   (dev_func),
        .blue   (dev_blue),
        .green  (dev_green),
        .red    (dev_red),
        .gray   (dev_gray),
        .pkt    (pkt)
    );

    dcp_shifter #(.W(PKT_BITS)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .shift(shift_en),
        .din  (pkt),
        .msb  (bit_msb),
        .last (bit_last)
    );

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sclk_q  <= 1'b0;
            dev_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SEND) begin
                if (tick) begin
                    sclk_q <= ~sclk_q;
                end
            end else begin
                sclk_q <= 1'b0;
            end
            if (accept) begin
                dev_q <= DW'(N_DEV - 1);
            end else if (pkt_end && (dev_q != '0)) begin
                dev_q <= dev_q - 1'b1;
            end
            if (state_q == ST_HOLD) begin
                hold_q <= hold_q + 1'b1;
            end else begin
                hold_q <= '0;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEND;
            ST_SEND: if (pkt_end && (dev_q == '0)) state_d = ST_HOLD;
            ST_HOLD: if (hold_q == HW'(HOLD_CYC - 1)) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sclk = sclk_q;
        sdo  = (state_q == ST_SEND) ? bit_msb : 1'b0;
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_FIN);
    end
endmodule

// File: rtl/dcp_tx_chk.sv
module dcp_tx_chk #(
    parameter int CLK_DIV = 2
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sclk,
    input logic sdo,
    input logic busy,
    input logic done
);
    localparam int HOLD = 18 * CLK_DIV;

    int hi_run;
    int lo_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run <= 0;
            lo_run <= 0;
        end else begin
            hi_run <= sclk ? hi_run + 1 : 0;
            if (sclk) lo_run <= 0;
            else if (lo_run < HOLD + 4) lo_run <= lo_run + 1;
        end
    end

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sdo));

    p_sdo_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo));

    p_high_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (hi_run < CLK_DIV));

    p_latch_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lo_run >= HOLD));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_busy_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> busy);
endmodule

bind dcp_tx dcp_tx_chk #(.CLK_DIV(CLK_DIV)) u_dcp_tx_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .sclk (sclk),
    .sdo  (sdo),
    .busy (busy),
    .done (done)
);

// File: tb/test_dcp_tx.sv
module test_dcp_tx;
    localparam int ND   = 3;
    localparam int DIV  = 2;
    localparam int PB   = 224;
    localparam int TOT  = PB * ND;
    localparam int HOLD = 18 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ND*5-1:0]   dev_func;
    logic [ND*7-1:0]   dev_blue, dev_green, dev_red;
    logic [ND*192-1:0] dev_gray;
    logic sclk, sdo, busy, done;

    logic [4:0]  fn [ND];
    logic [6:0]  bl [ND];
    logic [6:0]  gr [ND];
    logic [6:0]  rd [ND];
    logic [15:0] gs [ND][12];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int d = 0; d < ND; d++) begin
            dev_func[d*5 +: 5]  = fn[d];
            dev_blue[d*7 +: 7]  = bl[d];
            dev_green[d*7 +: 7] = gr[d];
            dev_red[d*7 +: 7]   = rd[d];
            for (int c = 0; c < 12; c++) dev_gray[d*192 + c*16 +: 16] = gs[d][c];
        end
    end

    dcp_tx #(.N_DEV(ND), .CLK_DIV(DIV)) i_dcp_tx (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dev_func(dev_func), .dev_blue(dev_blue), .dev_green(dev_green),
        .dev_red(dev_red), .dev_gray(dev_gray),
        .sclk(sclk), .sdo(sdo), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor
    logic cap [TOT];
    int  nrise, ndone, lo_run, hi_run;
    bit  mon_en = 0;
    logic prev_sclk, prev_sdo;

    always @(negedge clk) begin
        if (mon_en) begin
            if (sclk && !prev_sclk) begin
                if (nrise < TOT) cap[nrise] = sdo;
                nrise++;
                chk(lo_run == DIV, "R5 low width", lo_run, DIV);
                hi_run = 1;
            end else if (sclk) begin
                hi_run++;
                chk(sdo == prev_sdo, "R6 sdo moved while sclk high", sdo, prev_sdo);
            end
            if (!sclk && prev_sclk) begin
                chk(hi_run == DIV, "R5 high width", hi_run, DIV);
                lo_run = 1;
            end else if (!sclk && busy && !done) begin
                lo_run++;
            end
            if (done) begin
                ndone++;
                chk(lo_run == HOLD, "R7 latch gap", lo_run, HOLD);
            end
        end
        prev_sclk = sclk;
        prev_sdo  = sdo;
    end

    function automatic logic [5:0] get6(int base);
        logic [5:0] v = '0;
        for (int i = 0; i < 6; i++) v = {v[4:0], cap[base+i]};
        return v;
    endfunction

    function automatic logic [15:0] getn(int base, int n);
        logic [15:0] v = '0;
        for (int i = 0; i < n; i++) v = {v[14:0], cap[base+i]};
        return v;
    endfunction

    task automatic fill(input int seed);
        for (int d = 0; d < ND; d++) begin
            if (seed == 0) begin
                fn[d] = '0; bl[d] = '0; gr[d] = '0; rd[d] = '0;
                for (int c = 0; c < 12; c++) gs[d][c] = '0;
            end else if (seed == 1) begin
                fn[d] = '1; bl[d] = '1; gr[d] = '1; rd[d] = '1;
                for (int c = 0; c < 12; c++) gs[d][c] = '1;
            end else begin
                fn[d] = 5'((seed * 7 + d * 3) & 31);
                bl[d] = 7'((seed * 13 + d * 5 + 1) & 127);
                gr[d] = 7'((seed * 29 + d * 11 + 2) & 127);
                rd[d] = 7'((seed * 37 + d * 17 + 3) & 127);
                for (int c = 0; c < 12; c++)
                    gs[d][c] = 16'((seed * 40503 + d * 4099 + c * 257 + c * c * 31) & 16'hFFFF);
            end
        end
    endtask

    task automatic run_frame(input int seed, input bit inject);
        int waitc;
        fill(seed);
        nrise = 0; ndone = 0; lo_run = 0; hi_run = 0;
        @(negedge clk);
        mon_en = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        waitc = 0;
        while (!done && waitc < 20000) begin
            @(negedge clk);
            waitc++;
            if (inject && waitc == 100) start = 1'b1;   // R9 mid-frame request
            if (inject && waitc == 101) start = 1'b0;
        end
        chk(done == 1'b1, "R8 done seen", done, 1);
        if (inject) start = 1'b1;                      // R9 request in the done cycle
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R8 done one cycle", done, 0);
        chk(busy == 1'b0, "R8 busy falls after done", busy, 0);
        repeat (20) @(negedge clk);
        mon_en = 0;
        chk(busy == 1'b0 && sclk == 1'b0, "R9 no second frame", {busy, sclk}, 0);
        chk(nrise == TOT, "R3 pulse count", nrise, TOT);
        chk(ndone == 1, "R8 single done", ndone, 1);
        for (int s = 0; s < ND; s++) begin
            int b   = s * PB;
            int dev = ND - 1 - s;   // R4 farthest device first
            int g;
            chk(get6(b) == 6'h25, "R1 command", get6(b), 6'h25);
            chk(getn(b + 6, 5) == 16'(fn[dev]), "R2/R4 function", getn(b + 6, 5), fn[dev]);
            chk(getn(b + 11, 7) == 16'(bl[dev]), "R2/R4 blue", getn(b + 11, 7), bl[dev]);
            chk(getn(b + 18, 7) == 16'(gr[dev]), "R2/R4 green", getn(b + 18, 7), gr[dev]);
            chk(getn(b + 25, 7) == 16'(rd[dev]), "R2/R4 red", getn(b + 25, 7), rd[dev]);
            for (int k = 0; k < 12; k++) begin
                g = 11 - k;
                chk(getn(b + 32 + k * 16, 16) == gs[dev][g], "R2/R4 grayscale",
                    getn(b + 32 + k * 16, 16), gs[dev][g]);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        fill(0);
        repeat (3) @(negedge clk);
        chk({sclk, sdo, busy, done} == 4'b0, "R10 reset outputs", {sclk, sdo, busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({sclk, sdo, busy, done} == 4'b0, "R10 idle outputs", {sclk, sdo, busy, done}, 0);
        prev_sclk = sclk;
        prev_sdo  = sdo;
        run_frame(0, 1'b0);
        run_frame(1, 1'b0);
        run_frame(2, 1'b1);
        run_frame(3, 1'b0);
        run_frame(4, 1'b1);
        run_frame(5, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule